// File: doc/BRIEF.md
# One-Time-Programmable Partition Write Guard

This block stands between a programming agent and a one-time-programmable (OTP) fuse array that is divided into equal partitions of words. Every programming request names a partition, a word offset inside it and a data word. The guard reads the addressed word from the array, decides whether the request may go ahead, and then either programs the word or answers with an error. A refused request never reaches the array as a write.

The highest word of every partition is its digest slot. An accepted nonzero write to that slot seals the partition for good. After reset the guard rebuilds the seal of each partition by reading every digest slot in turn: a nonzero slot means sealed. Each partition carries a parameter mask of the lifecycle states in which it may be programmed. The array only turns bits from 0 to 1, so a request that would clear a bit already set is refused. Partitions marked erasable accept every request, sealed or not, once the device is in the decommissioned state, and each such request writes the all-ones erase pattern.

Top module: `otp_lock_gate`

## Requirements
- R1: After reset `reqReady` stays low while the guard reads the digest slot (offset WORDS-1) of partitions 0, 1, ... in that order, and a partition whose slot reads nonzero starts out sealed; only then does `reqReady` rise.
- R2: An accepted request reads the word at address {partition, offset}, then programs that address with the old contents ORed with the request data and gives `rspValid` with `rspErr` low.
- R3: Outside the decommissioned state, every request to a sealed partition is refused and leaves the array unchanged.
- R4: An accepted write to the digest slot seals its partition; a write of zero data to a digest slot is refused.
- R5: Outside the decommissioned state a request is refused unless bit (partition*8 + state) of `ALLOW_MASK` is set; states are coded Raw 0, TestUnlocked 1, TestLocked 2, Manuf 3, Prod 4, ProdEnd 5, RMA 6, Scrap 7. Defaults: partition 0 TestUnlocked, partition 1 Manuf, partition 2 Prod, partition 3 Manuf.
- R6: A request whose data has a 0 where the current word has a 1 is refused.
- R7: In the Scrap state a request to a partition whose `ERASE_MASK` bit is set (default partitions 1 and 2) is accepted even when sealed and writes all ones; a request to any other partition is refused.
- R8: A refused request ends with a one-cycle `rspValid` with `rspErr` high and never raises `otpWe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| lcState | input | 3 | Current lifecycle state, taken when a request is accepted |
| reqValid | input | 1 | Programming request present |
| reqReady | output | 1 | Guard can take a request |
| reqPart | input | PART_W | Partition index |
| reqOffset | input | OFF_W | Word offset in the partition |
| reqData | input | DATA_W | Bits to program |
| rspValid | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Request refused |
| otpReq | output | 1 | Array access request, held until acknowledged |
| otpWe | output | 1 | Access is a write |
| otpAddr | output | PART_W+OFF_W | Array word address |
| otpWdata | output | DATA_W | Word to program |
| otpAck | input | 1 | Array acknowledge, one cycle |
| otpRdata | input | DATA_W | Read word, valid with the acknowledge |

## Verification
The hardest situation to reach is a seal that exists only in the array's contents and never in a write the guard saw: the bench preloads its array model with a nonzero digest slot before reset, and later resets the guard a second time after it sealed a partition itself, so that both seals must be rebuilt from the reset scan. The decommission exception needs partitions sealed by earlier traffic, so the Scrap sweep runs last, after a sweep of every state, partition and offset has filled the array.

// File: rtl/otp_gate_pkg.sv
package otp_gate_pkg;

  typedef enum logic [2:0] {
    LC_RAW       = 3'd0,
    LC_TEST_OPEN = 3'd1,
    LC_TEST_SHUT = 3'd2,
    LC_MANUF     = 3'd3,
    LC_PROD      = 3'd4,
    LC_PROD_END  = 3'd5,
    LC_RMA       = 3'd6,
    LC_SCRAP     = 3'd7
  } lcState_e;

  localparam int LC_COUNT = 8;

  typedef struct packed {
    logic useScanAddr;
    logic scanCapture;
    logic capReq;
    logic capRead;
    logic commitLock;
  } gateStrobes_t;

endpackage

// File: rtl/otp_gate_dp.sv
module otp_gate_dp
  import otp_gate_pkg::*;
#(
  parameter int NUM_PART = 4,
  parameter int WORDS = 4,
  parameter int DATA_W = 8,
  parameter logic [NUM_PART*LC_COUNT-1:0] ALLOW_MASK = '0,
  parameter logic [NUM_PART-1:0] ERASE_MASK = '0,
  localparam int PART_W = $clog2(NUM_PART),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic clk,
  input  logic rstN,
  input  gateStrobes_t strobes,
  input  logic [2:0] lcState,
  input  logic [PART_W-1:0] reqPart,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] otpRdata,
  output logic [PART_W+OFF_W-1:0] otpAddr,
  output logic [DATA_W-1:0] otpWdata,
  output logic denyErr,
  output logic scanLast,
  output logic scanDone
);

  localparam logic [OFF_W-1:0] DIGEST_OFF = OFF_W'(WORDS - 1);

  logic [NUM_PART-1:0] lockVec;
  logic [PART_W-1:0] scanIdx;
  logic [PART_W-1:0] rPart;
  logic [OFF_W-1:0] rOff;
  logic [DATA_W-1:0] rData;
  logic [DATA_W-1:0] rCur;
  lcState_e rLc;
  logic zeroMode;
  logic isDigest;
  logic windowOpen;
  logic clearsBits;

  assign scanLast = (scanIdx == PART_W'(NUM_PART - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIdx  <= '0;
      scanDone <= 1'b0;
    end else if (strobes.scanCapture) begin
      scanIdx  <= scanLast ? '0 : scanIdx + 1'b1;
      scanDone <= scanDone | scanLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rPart <= '0;
      rOff  <= '0;
      rData <= '0;
      rLc   <= LC_RAW;
      rCur  <= '0;
    end else begin
      if (strobes.capReq) begin
        rPart <= reqPart;
        rOff  <= reqOffset;
        rData <= reqData;
        rLc   <= lcState_e'(lcState);
      end
      if (strobes.capRead) rCur <= otpRdata;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PART; p++) begin : g_lock
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) lockVec[p] <= 1'b0;
        else if (strobes.scanCapture && scanIdx == PART_W'(p))
          lockVec[p] <= |otpRdata;
        else if (strobes.commitLock && isDigest && rPart == PART_W'(p))
          lockVec[p] <= 1'b1;
      end

      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (lockVec[p] && scanDone) |=> lockVec[p]); // R3
    end
  endgenerate

  assign zeroMode   = (rLc == LC_SCRAP);
  assign isDigest   = (rOff == DIGEST_OFF);
  assign windowOpen = ALLOW_MASK[{rPart, rLc}];
  assign clearsBits = |(rCur & ~rData);

  always_comb begin
    if (zeroMode) denyErr = !ERASE_MASK[rPart];
    else denyErr = lockVec[rPart] || !windowOpen || clearsBits ||
                   (isDigest && rData == '0);
  end

  assign otpWdata = zeroMode ? '1 : (rCur | rData);
  assign otpAddr  = strobes.useScanAddr ? {scanIdx, DIGEST_OFF} : {rPart, rOff};

  AST_SEALED_NO_PROGRAM: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitLock && !zeroMode) |-> !lockVec[rPart]); // R3

  AST_DIGEST_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitLock && isDigest) |-> (otpWdata != '0)); // R4

endmodule

// File: rtl/otp_gate_ctrl.sv
module otp_gate_ctrl
  import otp_gate_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic reqReady,
  output logic rspValid,
  output logic rspErr,
  output logic otpReq,
  output logic otpWe,
  input  logic otpAck,
  input  logic denyErr,
  input  logic scanLast,
  input  logic scanDone,
  output gateStrobes_t strobes
);

  typedef enum logic [2:0] {
    ST_SCAN, ST_IDLE, ST_READ, ST_DECIDE, ST_WRITE, ST_RESP
  } ctrlState_e;

  ctrlState_e state;
  logic errReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_SCAN;
      errReg <= 1'b0;
    end else begin
      case (state)
        ST_SCAN:   if (otpAck && scanLast) state <= ST_IDLE;
        ST_IDLE:   if (reqValid) state <= ST_READ;
        ST_READ:   if (otpAck) state <= ST_DECIDE;
        ST_DECIDE: begin
          errReg <= denyErr;
          state  <= denyErr ? ST_RESP : ST_WRITE;
        end
        ST_WRITE:  if (otpAck) state <= ST_RESP;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    strobes.useScanAddr = (state == ST_SCAN);
    strobes.scanCapture = (state == ST_SCAN) && otpAck;
    strobes.capReq      = (state == ST_IDLE) && reqValid;
    strobes.capRead     = (state == ST_READ) && otpAck;
    strobes.commitLock  = (state == ST_WRITE) && otpAck;
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign rspErr   = rspValid && errReg;
  assign otpReq   = (state == ST_SCAN) || (state == ST_READ) || (state == ST_WRITE);
  assign otpWe    = (state == ST_WRITE);

  AST_NO_WRITE_ON_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (otpReq && otpWe) |-> !denyErr); // R8

  AST_READY_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> scanDone); // R1

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R8

endmodule

// File: rtl/otp_lock_gate.sv
module otp_lock_gate
  import otp_gate_pkg::*;
#(
  parameter int NUM_PART = 4,
  parameter int WORDS = 4,
  parameter int DATA_W = 8,
  parameter logic [NUM_PART*LC_COUNT-1:0] ALLOW_MASK = 32'h0810_0802,
  parameter logic [NUM_PART-1:0] ERASE_MASK = 4'b0110,
  localparam int PART_W = $clog2(NUM_PART),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic [2:0] lcState,
  input  logic reqValid,
  output logic reqReady,
  input  logic [PART_W-1:0] reqPart,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [DATA_W-1:0] reqData,
  output logic rspValid,
  output logic rspErr,
  output logic otpReq,
  output logic otpWe,
  output logic [PART_W+OFF_W-1:0] otpAddr,
  output logic [DATA_W-1:0] otpWdata,
  input  logic otpAck,
  input  logic [DATA_W-1:0] otpRdata
);

  gateStrobes_t strobes;
  logic denyErr;
  logic scanLast;
  logic scanDone;

  otp_gate_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspErr(rspErr), .otpReq(otpReq), .otpWe(otpWe),
    .otpAck(otpAck), .denyErr(denyErr), .scanLast(scanLast),
    .scanDone(scanDone), .strobes(strobes)
  );

  otp_gate_dp #(
    .NUM_PART(NUM_PART), .WORDS(WORDS), .DATA_W(DATA_W),
    .ALLOW_MASK(ALLOW_MASK), .ERASE_MASK(ERASE_MASK)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lcState(lcState),
    .reqPart(reqPart), .reqOffset(reqOffset), .reqData(reqData),
    .otpRdata(otpRdata), .otpAddr(otpAddr), .otpWdata(otpWdata),
    .denyErr(denyErr), .scanLast(scanLast), .scanDone(scanDone)
  );

endmodule

// File: tb/test_otp_lock_gate.sv
module test_otp_lock_gate;

  localparam int NP = 4;
  localparam int NW = 4;
  localparam int NWORD = NP * NW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] lcState = 3'd0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqPart = '0;
  logic [1:0] reqOffset = '0;
  logic [7:0] reqData = '0;
  logic rspValid, rspErr, otpReq, otpWe, otpAck;
  logic [3:0] otpAddr;
  logic [7:0] otpWdata, otpRdata;

  logic [7:0] mem [NWORD];
  logic expLock [NP];
  int wrCount = 0;
  int readLog [8];
  int readCnt = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Default policy as stated in the requirements (R5, R7)
  function automatic bit allowed(int p, int lc);
    case (p)
      0: return lc == 1;
      1: return lc == 3;
      2: return lc == 4;
      default: return lc == 3;
    endcase
  endfunction

  function automatic bit erasable(int p);
    return p == 1 || p == 2;
  endfunction

  always #10 clk = ~clk;

  otp_lock_gate i_otp_lock_gate (
    .clk(clk), .rstN(rstN), .lcState(lcState), .reqValid(reqValid),
    .reqReady(reqReady), .reqPart(reqPart), .reqOffset(reqOffset),
    .reqData(reqData), .rspValid(rspValid), .rspErr(rspErr),
    .otpReq(otpReq), .otpWe(otpWe), .otpAddr(otpAddr), .otpWdata(otpWdata),
    .otpAck(otpAck), .otpRdata(otpRdata)
  );

  // Array model: one-cycle acknowledge, unprogrammed words read zero
  always @(posedge clk) begin
    if (!rstN) otpAck <= 1'b0;
    else if (otpReq && !otpAck) begin
      otpAck <= 1'b1;
      if (otpWe) begin
        mem[otpAddr] <= otpWdata;
        wrCount <= wrCount + 1;
      end else begin
        otpRdata <= mem[otpAddr];
        if (readCnt < 8) readLog[readCnt] <= int'(otpAddr);
        readCnt <= readCnt + 1;
      end
    end else otpAck <= 1'b0;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(string req);
    rstN = 1'b0;
    readCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(req, int'(reqReady), 0);
    while (!reqReady) @(negedge clk);
    chk(req, readCnt, NP);
    for (int p = 0; p < NP; p++) begin
      chk(req, readLog[p], p * NW + NW - 1);
      expLock[p] = (mem[p * NW + NW - 1] != 8'h00);
    end
  endtask

  task automatic op(string req, int lc, int p, int off, logic [7:0] d);
    logic [7:0] cur;
    logic [7:0] expWord;
    bit ok;
    int w0;
    int addr;
    addr = p * NW + off;
    cur = mem[addr];
    if (lc == 7) ok = erasable(p);
    else ok = allowed(p, lc) && !expLock[p] && ((cur & ~d) == 8'h00) &&
              !(off == NW - 1 && d == 8'h00);
    expWord = !ok ? cur : (lc == 7 ? 8'hFF : (cur | d));
    w0 = wrCount;
    lcState = 3'(lc);
    reqPart = 2'(p);
    reqOffset = 2'(off);
    reqData = d;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    chk(req, int'(rspErr), int'(!ok));
    @(negedge clk);
    chk(req, int'(mem[addr]), int'(expWord));
    chk("R8", wrCount - w0, ok ? 1 : 0);
    if (ok && off == NW - 1) expLock[p] = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NWORD; i++) mem[i] = 8'h00;
    mem[15] = 8'h3C;   // partition 3 sealed in an earlier life
    mem[12] = 8'h01;

    // R1: reset scan rebuilds the seal of partition 3
    doReset("R1");

    // R2 R3 R5: every non-Scrap state, partition and data offset
    for (int lc = 0; lc < 7; lc++)
      for (int p = 0; p < NP; p++)
        for (int off = 0; off < NW - 1; off++)
          op("R5", lc, p, off, mem[p * NW + off] | (8'h01 << ((lc + p + off) % 8)));

    // R2: accepted OR-program on a fresh word in its window
    op("R2", 4, 2, 1, 8'hA0 | mem[9]);
    // R6: clearing a set bit is refused
    op("R6", 3, 1, 0, 8'h00);
    op("R6", 1, 0, 2, mem[2] & 8'hFE);
    // R4: zero digest refused, nonzero digest seals
    op("R4", 3, 1, 3, 8'h00);
    op("R4", 3, 1, 3, 8'h5A);
    op("R3", 3, 1, 1, mem[5] | 8'h80);
    op("R3", 3, 3, 0, mem[12] | 8'h02);

    // R1: seals survive a second reset only through the scan
    doReset("R1");
    op("R3", 3, 1, 2, mem[6] | 8'h40);
    op("R2", 1, 0, 1, mem[1] | 8'h10);

    // R7: decommission erase sweep, sealed or not
    for (int p = 0; p < NP; p++)
      for (int off = 0; off < NW; off++)
        op("R7", 7, p, off, 8'h11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule